// File: doc/BRIEF.md
# Video Control Command Decoder

This block takes a stream of command bytes, one byte per cycle in which `in_valid` is high, and turns it into updates of a bank of 8-bit video control registers. A command opens with a marker byte of 0xAF and an opcode byte. Opcode 0x20 carries a register index and a value. Opcode 0x6A is a nine-byte copy command, which this block skips over and then reports with a single-cycle pulse. Any other opcode is dropped.

Two special writes to index 0xFF control when changes become visible. Value 0x00 freezes the bank: later writes only update a hidden shadow copy. Value 0xFF releases the bank and moves the whole shadow copy into the active registers in one edge. The active registers drive wide fields for a display timing generator. Most fields are stored high byte first. The pixel clock divider is stored low byte first.

Top module: `vidcmd_decoder`

## Requirements
- R1: After reset the bank is unfrozen (`locked` = 0), `copy_done` is 0, and every output field is 0.
- R2: The sequence 0xAF, 0x20, idx, val with idx below NUM_REGS and the bank unfrozen sets register idx to val. The new value shows on the outputs from the second rising edge after the val byte is accepted.
- R3: In the idle state, a byte other than 0xAF is thrown away. After 0xAF, an opcode other than 0x20 or 0x6A (0xAF included) sends the decoder back to idle with no write.
- R4: Writing 0x00 to index 0xFF sets `locked`. While it is set, writes change only the shadow copy and the outputs hold their values.
- R5: Writing 0xFF to index 0xFF clears `locked` and copies every shadow register into the active set on the same edge.
- R6: Timing field k (k = 0..11, at bits [16k+15:16k] of `timing_fields`) takes its high byte from register 1+2k and its low byte from register 2+2k.
- R7: `pixclk_div` takes its low byte from register 0x1B and its high byte from register 0x1C.
- R8: `base16_addr` is registers {0x20, 0x21, 0x22}, and `base8_addr` is {0x26, 0x27, 0x28}, most significant byte first. `color_depth` is register 0x00.
- R9: 0xAF, 0x6A and the seven payload bytes after them cause no write, even when the payload looks like a write command. `copy_done` is high for exactly the one cycle that follows acceptance of the last payload byte.
- R10: Bytes presented while `in_valid` is low are ignored.
- R11: A write to an index from NUM_REGS to 0xFE changes nothing. A write to 0xFF with a value other than 0x00 or 0xFF changes nothing, `locked` included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A command byte is present |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Always high; the decoder takes one byte per cycle |
| locked | output | 1 | Bank is frozen; writes go to the shadow copy only |
| copy_done | output | 1 | One-cycle pulse at the end of a skipped copy command |
| color_depth | output | 8 | Colour depth selector (register 0x00) |
| base16_addr | output | 24 | 16-bpp surface base address |
| base8_addr | output | 24 | 8-bpp surface base address |
| timing_fields | output | 192 | Twelve 16-bit timing fields, stored high byte first |
| pixclk_div | output | 16 | Pixel clock divider, stored low byte first |

## Verification
Write strobes leave the parser through a register, so a write is applied in the bank during the same cycle in which the parser accepts the first byte of the next command. The same overlap happens when the release command's bulk commit coincides with the next command's marker byte. The bench creates this by sending commands back to back with no idle cycle, including a write placed directly after a copy command and a release followed at once by further writes. In each case it checks that both the earlier update and the later command land as the requirements state. Fields are compared against a bench-side register model, and copy pulses are matched one-to-one against a queue of expected completions.

// File: rtl/vidcmd_pkg.sv
package vidcmd_pkg;

    localparam logic [7:0] CMD_MARK    = 8'hAF;
    localparam logic [7:0] OPC_REGWR   = 8'h20;
    localparam logic [7:0] OPC_COPY    = 8'h6A;
    localparam logic [7:0] CTRL_IDX    = 8'hFF;
    localparam logic [7:0] CTRL_FREEZE = 8'h00;
    localparam logic [7:0] CTRL_THAW   = 8'hFF;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_OPCODE,
        PS_INDEX,
        PS_VALUE,
        PS_SKIP
    } parse_state_e;

endpackage

// File: rtl/vidcmd_parser.sv
module vidcmd_parser
    import vidcmd_pkg::*;
#(
    parameter int COPY_BYTES = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       wr_en,
    output logic [7:0] wr_idx,
    output logic [7:0] wr_val,
    output logic       copy_done
);

    localparam int PAYLOAD = COPY_BYTES - 2;
    localparam int CNT_W   = $clog2(PAYLOAD + 1);

    typedef struct packed {
        parse_state_e     state;
        logic [7:0]       idx;
        logic [CNT_W-1:0] left;
        logic             wr_en;
        logic [7:0]       wr_idx;
        logic [7:0]       wr_val;
        logic             done;
    } parse_t;

    parse_t p_d, p_q;

    always_comb begin
        p_d       = p_q;
        p_d.wr_en = 1'b0;
        p_d.done  = 1'b0;
        if (in_valid) begin
            case (p_q.state)
                PS_IDLE: begin
                    if (in_data == CMD_MARK) p_d.state = PS_OPCODE;
                end
                PS_OPCODE: begin
                    if (in_data == OPC_REGWR) begin
                        p_d.state = PS_INDEX;
                    end else if (in_data == OPC_COPY) begin
                        p_d.state = PS_SKIP;
                        p_d.left  = CNT_W'(PAYLOAD - 1);
                    end else begin
                        p_d.state = PS_IDLE;
                    end
                end
                PS_INDEX: begin
                    p_d.idx   = in_data;
                    p_d.state = PS_VALUE;
                end
                PS_VALUE: begin
                    p_d.wr_en  = 1'b1;
                    p_d.wr_idx = p_q.idx;
                    p_d.wr_val = in_data;
                    p_d.state  = PS_IDLE;
                end
                PS_SKIP: begin
                    if (p_q.left == '0) begin
                        p_d.done  = 1'b1;
                        p_d.state = PS_IDLE;
                    end else begin
                        p_d.left = p_q.left - 1'b1;
                    end
                end
                default: p_d.state = PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q       <= '0;
            p_q.state <= PS_IDLE;
        end else begin
            p_q <= p_d;
        end
    end

    assign wr_en     = p_q.wr_en;
    assign wr_idx    = p_q.wr_idx;
    assign wr_val    = p_q.wr_val;
    assign copy_done = p_q.done;

endmodule

// File: rtl/vidcmd_regbank.sv
module vidcmd_regbank
    import vidcmd_pkg::*;
#(
    parameter int NUM_REGS = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [7:0]            wr_idx,
    input  logic [7:0]            wr_val,
    output logic                  locked,
    output logic [NUM_REGS*8-1:0] act_flat,
    output logic [NUM_REGS*8-1:0] shd_flat
);

    typedef struct packed {
        logic                          frozen;
        logic [NUM_REGS-1:0][7:0]      act;
        logic [NUM_REGS-1:0][7:0]      shd;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        if (wr_en) begin
            if (wr_idx == CTRL_IDX) begin
                if (wr_val == CTRL_FREEZE) begin
                    b_d.frozen = 1'b1;
                end else if (wr_val == CTRL_THAW) begin
                    b_d.frozen = 1'b0;
                    b_d.act    = b_q.shd;
                end
            end else begin
                for (int r = 0; r < NUM_REGS; r++) begin
                    if (wr_idx == 8'(r)) begin
                        b_d.shd[r] = wr_val;
                        if (!b_q.frozen) b_d.act[r] = wr_val;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_q <= '0;
        else        b_q <= b_d;
    end

    assign locked   = b_q.frozen;
    assign act_flat = b_q.act;
    assign shd_flat = b_q.shd;

endmodule

// File: rtl/vidcmd_fields.sv
module vidcmd_fields #(
    parameter int NUM_REGS    = 64,
    parameter int N_TIMING    = 12,
    parameter int TIMING_BASE = 8'h01,
    parameter int PIXCLK_IDX  = 8'h1B,
    parameter int BASE16_IDX  = 8'h20,
    parameter int BASE8_IDX   = 8'h26,
    parameter int DEPTH_IDX   = 8'h00
) (
    input  logic [NUM_REGS*8-1:0]   act_flat,
    output logic [7:0]              color_depth,
    output logic [23:0]             base16_addr,
    output logic [23:0]             base8_addr,
    output logic [N_TIMING*16-1:0]  timing_fields,
    output logic [15:0]             pixclk_div
);

    // Timing fields: high byte at the even-offset index, low byte just above.
    for (genvar k = 0; k < N_TIMING; k++) begin : g_tim
        localparam int HI = TIMING_BASE + 2 * k;
        assign timing_fields[16*k +: 16] = {act_flat[8*HI +: 8], act_flat[8*(HI+1) +: 8]};
    end

    // Address fields: three bytes, most significant at the lowest index.
    for (genvar j = 0; j < 3; j++) begin : g_addr
        assign base16_addr[8*(2-j) +: 8] = act_flat[8*(BASE16_IDX+j) +: 8];
        assign base8_addr[8*(2-j) +: 8]  = act_flat[8*(BASE8_IDX+j) +: 8];
    end

    // Pixel clock divider is the one field stored low byte first.
    assign pixclk_div  = {act_flat[8*(PIXCLK_IDX+1) +: 8], act_flat[8*PIXCLK_IDX +: 8]};
    assign color_depth = act_flat[8*DEPTH_IDX +: 8];

endmodule

// File: rtl/vidcmd_decoder.sv
module vidcmd_decoder #(
    parameter int NUM_REGS   = 64,
    parameter int N_TIMING   = 12,
    parameter int COPY_BYTES = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [7:0]             in_data,
    output logic                   in_ready,
    output logic                   locked,
    output logic                   copy_done,
    output logic [7:0]             color_depth,
    output logic [23:0]            base16_addr,
    output logic [23:0]            base8_addr,
    output logic [N_TIMING*16-1:0] timing_fields,
    output logic [15:0]            pixclk_div
);

    logic                  wr_en;
    logic [7:0]            wr_idx;
    logic [7:0]            wr_val;
    logic [NUM_REGS*8-1:0] act_flat;
    logic [NUM_REGS*8-1:0] shd_flat;

    assign in_ready = 1'b1;

    vidcmd_parser #(.COPY_BYTES(COPY_BYTES)) u_parse (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_val    (wr_val),
        .copy_done (copy_done)
    );

    vidcmd_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_val   (wr_val),
        .locked   (locked),
        .act_flat (act_flat),
        .shd_flat (shd_flat)
    );

    vidcmd_fields #(.NUM_REGS(NUM_REGS), .N_TIMING(N_TIMING)) u_fields (
        .act_flat      (act_flat),
        .color_depth   (color_depth),
        .base16_addr   (base16_addr),
        .base8_addr    (base8_addr),
        .timing_fields (timing_fields),
        .pixclk_div    (pixclk_div)
    );

endmodule

// File: rtl/vidcmd_checker.sv
module vidcmd_checker #(
    parameter int NUM_REGS = 64
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic                  wr_en,
    input logic [7:0]            wr_idx,
    input logic [7:0]            wr_val,
    input logic                  locked,
    input logic                  copy_done,
    input logic [NUM_REGS*8-1:0] act_flat,
    input logic [NUM_REGS*8-1:0] shd_flat
);

    logic       thaw_cmd;
    logic       odd_ctrl;
    logic       far_idx;
    logic       pend_q;
    logic [7:0] pidx_q;
    logic [7:0] pval_q;
    logic [7:0] act_at;

    assign thaw_cmd = wr_en && wr_idx == 8'hFF && wr_val == 8'hFF;
    assign odd_ctrl = wr_en && wr_idx == 8'hFF && wr_val != 8'h00 && wr_val != 8'hFF;
    assign far_idx  = wr_en && 32'(wr_idx) >= NUM_REGS && wr_idx != 8'hFF;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            pidx_q <= '0;
            pval_q <= '0;
        end else begin
            pend_q <= wr_en && !locked && 32'(wr_idx) < NUM_REGS;
            pidx_q <= wr_idx;
            pval_q <= wr_val;
        end
    end

    always_comb begin
        act_at = '0;
        for (int r = 0; r < NUM_REGS; r++)
            if (pidx_q == 8'(r)) act_at = act_flat[8*r +: 8];
    end

    // R2: an unfrozen write lands in the active register on the next edge
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> act_at == pval_q);

    // R4: while frozen, only the thaw command can move the active set
    a_r4_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !thaw_cmd) |=> $stable(act_flat));

    // R5: thaw moves the complete shadow set in one edge
    a_r5_bulk_commit: assert property (@(posedge clk) disable iff (!rst_n)
        thaw_cmd |=> (act_flat == $past(shd_flat)) && !locked);

    // R9: copy completion is a single-cycle pulse
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        copy_done |=> !copy_done);

    // R10: an idle input produces no write and no pulse
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!wr_en && !copy_done));

    // R11: out-of-range index leaves both copies alone
    a_r11_far_index: assert property (@(posedge clk) disable iff (!rst_n)
        far_idx |=> ($stable(act_flat) && $stable(shd_flat)));

    // R11: unrecognised control value leaves the freeze state alone
    a_r11_odd_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        odd_ctrl |=> ($stable(locked) && $stable(act_flat)));

endmodule

bind vidcmd_decoder vidcmd_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_val    (wr_val),
    .locked    (locked),
    .copy_done (copy_done),
    .act_flat  (act_flat),
    .shd_flat  (shd_flat)
);

// File: tb/sim_vidcmd_decoder.sv
module sim_vidcmd_decoder;

    localparam int NR = 64;
    localparam int NT = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          in_ready;
    logic          locked;
    logic          copy_done;
    logic [7:0]    color_depth;
    logic [23:0]   base16_addr;
    logic [23:0]   base8_addr;
    logic [NT*16-1:0] timing_fields;
    logic [15:0]   pixclk_div;

    int vectors = 0;
    int misses  = 0;
    bit finished = 0;

    logic [7:0] m_act [NR];
    logic [7:0] m_shd [NR];
    bit         m_lock;
    int         exp_copy[$];
    logic       prev_done = 1'b0;
    bit         mon_on = 0;

    always #4 clk = ~clk;

    vidcmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .locked(locked), .copy_done(copy_done),
        .color_depth(color_depth), .base16_addr(base16_addr),
        .base8_addr(base8_addr), .timing_fields(timing_fields),
        .pixclk_div(pixclk_div)
    );

    task automatic cmp(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor for copy completions (R9)
    always @(negedge clk) begin
        if (mon_on) begin
            if (copy_done) begin
                vectors++;
                if (exp_copy.size() == 0) begin
                    misses++;
                    $display("FAIL R9 unexpected copy_done: actual 1 expected 0");
                end else begin
                    void'(exp_copy.pop_front());
                end
                if (prev_done) begin
                    misses++;
                    $display("FAIL R9 pulse width: actual 2+ cycles expected 1");
                end
            end
            prev_done = copy_done;
        end
    end

    task automatic model_write(input logic [7:0] idx, input logic [7:0] val);
        if (idx == 8'hFF) begin
            if (val == 8'h00) m_lock = 1;
            else if (val == 8'hFF) begin
                m_lock = 0;
                for (int r = 0; r < NR; r++) m_act[r] = m_shd[r];
            end
        end else if (int'(idx) < NR) begin
            m_shd[idx] = val;
            if (!m_lock) m_act[idx] = val;
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        @(posedge clk);
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] val);
        send(8'hAF); send(8'h20); send(idx); send(val);
        model_write(idx, val);
    endtask

    task automatic copy_cmd(input logic [7:0] p [7]);
        send(8'hAF); send(8'h6A);
        for (int i = 0; i < 7; i++) send(p[i]);
        exp_copy.push_back(1);
    endtask

    task automatic settle();
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input string req);
        cmp(req, "color_depth", {24'h0, color_depth}, {24'h0, m_act[0]});
        cmp(req, "base16", {8'h0, base16_addr}, {8'h0, m_act[8'h20], m_act[8'h21], m_act[8'h22]});
        cmp(req, "base8", {8'h0, base8_addr}, {8'h0, m_act[8'h26], m_act[8'h27], m_act[8'h28]});
        for (int k = 0; k < NT; k++)
            cmp(req, $sformatf("timing%0d", k), {16'h0, timing_fields[16*k +: 16]},
                {16'h0, m_act[1+2*k], m_act[2+2*k]});
        cmp(req, "pixclk", {16'h0, pixclk_div}, {16'h0, m_act[8'h1C], m_act[8'h1B]});
        cmp(req, "locked", {31'h0, locked}, {31'h0, m_lock});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [7:0] pl [7];
        for (int r = 0; r < NR; r++) begin m_act[r] = 8'h00; m_shd[r] = 8'h00; end
        m_lock = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1;
        @(negedge clk);

        // R1: reset state
        check_all("R1");
        cmp("R1", "copy_done", {31'h0, copy_done}, 32'h0);
        cmp("R1", "in_ready", {31'h0, in_ready}, 32'h1);

        // R2 / R6: timing registers, high byte first
        wr(8'h01, 8'h12); wr(8'h02, 8'h34);
        settle();
        cmp("R6", "field0", {16'h0, timing_fields[15:0]}, 32'h1234);
        for (int i = 3; i <= 8'h18; i++) wr(8'(i), 8'(i * 7 + 3));
        settle();
        check_all("R2");

        // R7: pixel clock divider, low byte first
        wr(8'h1B, 8'hCD); wr(8'h1C, 8'hAB);
        settle();
        cmp("R7", "pixclk", {16'h0, pixclk_div}, 32'hABCD);

        // R8: address fields and depth
        wr(8'h20, 8'h01); wr(8'h21, 8'h02); wr(8'h22, 8'h03);
        wr(8'h26, 8'hA1); wr(8'h27, 8'hB2); wr(8'h28, 8'hC3);
        wr(8'h00, 8'h01);
        settle();
        cmp("R8", "base16", {8'h0, base16_addr}, 32'h010203);
        cmp("R8", "base8", {8'h0, base8_addr}, 32'hA1B2C3);
        cmp("R8", "depth", {24'h0, color_depth}, 32'h01);

        // R3: stray bytes and unknown opcodes
        send(8'h00); send(8'h20); send(8'h55);
        send(8'hAF); send(8'h21); send(8'h00); send(8'h05);
        send(8'hAF); send(8'hAF); send(8'h20); send(8'h00); send(8'hEE);
        settle();
        check_all("R3");

        // R10: bytes with valid low
        @(negedge clk); in_valid = 1'b0; in_data = 8'hAF;
        @(negedge clk); in_data = 8'h20;
        @(negedge clk); in_data = 8'h00;
        @(negedge clk); in_data = 8'h77;
        settle();
        check_all("R10");

        // R11: far index and odd control value
        wr(8'h50, 8'h99); wr(8'hFF, 8'h5A);
        settle();
        check_all("R11");

        // R4: freeze, then stage writes
        wr(8'hFF, 8'h00);
        wr(8'h01, 8'hEE); wr(8'h1B, 8'h44); wr(8'h20, 8'h99); wr(8'h00, 8'h00);
        settle();
        check_all("R4");
        cmp("R4", "field0 held", {16'h0, timing_fields[15:0]}, 32'h1234);

        // R5: thaw commits, followed back to back by a live write
        wr(8'hFF, 8'hFF);
        wr(8'h02, 8'h56);
        settle();
        check_all("R5");
        cmp("R5", "field0 committed", {16'h0, timing_fields[15:0]}, 32'hEE56);

        // R9: copy with a payload that imitates a write, then a back-to-back write
        pl = '{8'hAF, 8'h20, 8'h00, 8'h77, 8'hAF, 8'h20, 8'h01};
        copy_cmd(pl);
        wr(8'h28, 8'h5C);
        settle();
        check_all("R9");
        pl = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h00, 8'h00};
        copy_cmd(pl);
        copy_cmd(pl);
        settle();
        cmp("R9", "copies pending", exp_copy.size(), 32'h0);
        check_all("R9");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule